// File: doc/BRIEF.md
# Inclusive Shared-Cache Read Resolver

This block controls one slice of a last-level cache that several cores share and that always contains every line held in any core's private caches. For each resident line it keeps a presence vector with one bit per core, a mark saying that one core may hold a modified copy, and the identity of that core. When a core asks for a line, the controller decides where the data comes from. A miss is fetched from main memory. A hit on an unmarked line is answered from the slice's own array. A hit on a marked line is answered by snooping exactly the one core that may have modified it, so no broadcast is needed.

A request can be a plain read or a read for ownership. An ownership read leaves the requester as the only present core and as the possible modifier. Every other present core receives a back-invalidate. On a miss in a full set, the least recently used way is evicted. If that line is marked, its owner is snooped first. All present cores are then back-invalidated to keep inclusion, and dirty data is written back. The ring transport and the DRAM are abstracted as simple valid/response ports. Requests are handled one at a time.

Top module: `llc_slice_resolver`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, mem_req_valid, snp_valid, binv_valid and wb_valid are 0. Every way is invalid, so the first access to any line misses.
- R2: A request that misses issues exactly one memory read with the line-aligned address (the low 6 offset bits zero). The response then carries rsp_src = 0 and the data returned by memory.
- R3: A request that hits a line with no modifier mark, or whose mark names the requester itself, is answered with rsp_src = 1 and the array data, without any memory read or snoop.
- R4: A request that hits a line marked as possibly modified by another core issues exactly one snoop, with snp_core set to that core. The response carries rsp_src = 2, and on a dirty snoop reply it carries the snooped data.
- R5: Dirty data returned by a snoop is written into the array and the modifier mark is cleared, so a later read by another core is answered from the array (rsp_src = 1) with that data and without a snoop.
- R6: An ownership request (req_own = 1) back-invalidates, in its response cycle, every other core marked present, with binv_mask bit i standing for core i. Afterwards the requester is the only present core and the owner. A repeat ownership request by the same core needs no snoop.
- R7: While a set still has an invalid way, a miss fills that way: no back-invalidate and no writeback occur.
- R8: Evicting a valid line asserts binv_valid with binv_mask equal to the victim's presence vector and binv_addr equal to its line address. If the line holds dirty data, wb_valid is asserted with that data and address.
- R9: In a full set, the victim is the least recently used way. Every response, hit or fill, makes its way the most recently used.
- R10: Evicting a line that carries a modifier mark first snoops its owner. Dirty data from that snoop is what is written back.
- R11: The set index is the address bits directly above the 6 offset bits (bits 7:6 by default). Lines with the same tag in different sets coexist without evicting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_core | input | CID_W | Requesting core |
| req_addr | input | ADDR_W | Byte address of the request |
| req_own | input | 1 | 1 = read for ownership, 0 = shared read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_core | output | CID_W | Core the response goes to |
| rsp_src | output | 2 | 0 memory, 1 shared array, 2 snooped core |
| rsp_data | output | DATA_W | Line payload |
| mem_req_valid | output | 1 | Memory read pending (held until reply) |
| mem_req_addr | output | ADDR_W | Line-aligned memory read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W | Memory read data |
| snp_valid | output | 1 | Snoop pending (held until reply) |
| snp_core | output | CID_W | Core being snooped |
| snp_addr | output | ADDR_W | Line address being snooped |
| snp_rsp_valid | input | 1 | Snoop reply valid |
| snp_rsp_dirty | input | 1 | Snoop reply carries modified data |
| snp_rsp_data | input | DATA_W | Snooped data |
| binv_valid | output | 1 | Back-invalidate pulse |
| binv_mask | output | CORES | Cores to invalidate, bit i = core i |
| binv_addr | output | ADDR_W | Line address to invalidate |
| wb_valid | output | 1 | Writeback pulse to memory |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_data | output | DATA_W | Writeback data |

## Verification
The hardest case to reach is the eviction of a line that one core may have modified. Reaching it needs a full set, an ownership request that marks a line, and an LRU order in which that marked line is the oldest. The stimulus fills one set with twelve lines and places the ownership request on one of them. It then re-reads every other resident line so that the marked line ages to the bottom. The next miss must then show a snoop of the owner, followed by a back-invalidate and a writeback that carries the snooped data. The same set also exercises evictions of a clean line and of a line dirtied by an earlier snoop.

// File: rtl/llc_pkg.sv
package llc_pkg;
  typedef enum logic [1:0] {
    SRC_MEM = 2'd0,
    SRC_ARR = 2'd1,
    SRC_SNP = 2'd2
  } rsrc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_SNOOP,
    ST_EVSNP,
    ST_EVICT,
    ST_MEMRD,
    ST_RESP
  } st_e;
endpackage

// File: rtl/llc_way_match.sv
module llc_way_match #(
  parameter int WAYS  = 12,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    hit     = |eq;
    hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (eq[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/llc_victim_sel.sv
module llc_victim_sel #(
  parameter int WAYS  = 12,
  parameter int AGE_W = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*AGE_W-1:0] ages,
  output logic [WAY_W-1:0]      victim
);
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;
  logic [AGE_W-1:0] old_age;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    old_way = '0;
    old_age = ages[0 +: AGE_W];
    for (int w = 1; w < WAYS; w++) begin
      if (ages[w*AGE_W +: AGE_W] > old_age) begin
        old_age = ages[w*AGE_W +: AGE_W];
        old_way = WAY_W'(w);
      end
    end
    victim = any_free ? free_way : old_way;
  end
endmodule

// File: rtl/llc_lru_age.sv
module llc_lru_age #(
  parameter int WAYS  = 12,
  parameter int AGE_W = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*AGE_W-1:0] ages,
  input  logic [WAY_W-1:0]      touch,
  output logic [WAYS*AGE_W-1:0] ages_nxt
);
  logic [AGE_W-1:0] touched_age;

  always_comb begin
    touched_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (touch == WAY_W'(w)) touched_age = ages[w*AGE_W +: AGE_W];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    always_comb begin
      if (touch == WAY_W'(w))
        ages_nxt[w*AGE_W +: AGE_W] = '0;
      else if (ages[w*AGE_W +: AGE_W] < touched_age)
        ages_nxt[w*AGE_W +: AGE_W] = ages[w*AGE_W +: AGE_W] + AGE_W'(1);
      else
        ages_nxt[w*AGE_W +: AGE_W] = ages[w*AGE_W +: AGE_W];
    end
  end
endmodule

// File: rtl/llc_slice_resolver.sv
module llc_slice_resolver
  import llc_pkg::*;
#(
  parameter int CORES      = 4,
  parameter int WAYS       = 12,
  parameter int SETS       = 4,
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64,
  parameter int DATA_W     = 64,
  localparam int CID_W = $clog2(CORES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CID_W-1:0]  req_core,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_own,
  output logic              rsp_valid,
  output logic [CID_W-1:0]  rsp_core,
  output logic [1:0]        rsp_src,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              snp_valid,
  output logic [CID_W-1:0]  snp_core,
  output logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_rsp_valid,
  input  logic              snp_rsp_dirty,
  input  logic [DATA_W-1:0] snp_rsp_data,
  output logic              binv_valid,
  output logic [CORES-1:0]  binv_mask,
  output logic [ADDR_W-1:0] binv_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [SET_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  // Per-line state
  logic              v_q    [SETS][WAYS];
  logic              d_q    [SETS][WAYS];
  logic              m_q    [SETS][WAYS];
  logic [CID_W-1:0]  own_q  [SETS][WAYS];
  logic [CORES-1:0]  pres_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] dat_q  [SETS][WAYS];
  logic [AGE_W-1:0]  age_q  [SETS][WAYS];

  // Transaction registers
  st_e              st_q;
  logic [CID_W-1:0] cur_core;
  logic             cur_own;
  logic [SET_W-1:0] cur_set;
  logic [TAG_W-1:0] cur_tag;
  logic [WAY_W-1:0] cur_way;
  rsrc_e            cur_src;

  // Flattened view of the addressed set
  logic [WAYS-1:0]       set_valid;
  logic [WAYS*TAG_W-1:0] set_tags;
  logic [WAYS*AGE_W-1:0] set_ages;
  logic [WAYS*AGE_W-1:0] ages_nxt;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w]                = v_q[cur_set][w];
      set_tags[w*TAG_W +: TAG_W]  = tag_q[cur_set][w];
      set_ages[w*AGE_W +: AGE_W]  = age_q[cur_set][w];
    end
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] vic_way;

  llc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid(set_valid), .tags(set_tags), .tag(cur_tag),
    .hit(hit), .hit_way(hit_way)
  );

  llc_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W)) u_victim (
    .valid(set_valid), .ages(set_ages), .victim(vic_way)
  );

  llc_lru_age #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
    .ages(set_ages), .touch(cur_way), .ages_nxt(ages_nxt)
  );

  // Named internal events for the checker
  logic             lookup_fire;
  logic             lookup_hit;
  logic             lookup_mod_other;
  logic [CORES-1:0] core_bit;

  assign lookup_fire      = (st_q == ST_LOOKUP);
  assign lookup_hit       = lookup_fire && hit;
  assign lookup_mod_other = lookup_hit && m_q[cur_set][hit_way] &&
                            (own_q[cur_set][hit_way] != cur_core);
  assign core_bit         = CORES'(1) << cur_core;

  // Current way view
  logic [CORES-1:0]  cw_pres;
  logic [TAG_W-1:0]  cw_tag;
  logic [DATA_W-1:0] cw_data;
  logic [CID_W-1:0]  cw_owner;
  logic              cw_dirty;
  logic [CORES-1:0]  others;

  assign cw_pres  = pres_q[cur_set][cur_way];
  assign cw_tag   = tag_q[cur_set][cur_way];
  assign cw_data  = dat_q[cur_set][cur_way];
  assign cw_owner = own_q[cur_set][cur_way];
  assign cw_dirty = d_q[cur_set][cur_way];
  assign others   = cw_pres & ~core_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_core <= '0;
      cur_own  <= 1'b0;
      cur_set  <= '0;
      cur_tag  <= '0;
      cur_way  <= '0;
      cur_src  <= SRC_MEM;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          v_q[s][w]    <= 1'b0;
          d_q[s][w]    <= 1'b0;
          m_q[s][w]    <= 1'b0;
          own_q[s][w]  <= '0;
          pres_q[s][w] <= '0;
          tag_q[s][w]  <= '0;
          dat_q[s][w]  <= '0;
          age_q[s][w]  <= AGE_W'(w);
        end
      end
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            cur_core <= req_core;
            cur_own  <= req_own;
            cur_set  <= set_of(req_addr);
            cur_tag  <= tag_of(req_addr);
            st_q     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            cur_way <= hit_way;
            if (lookup_mod_other) begin
              st_q <= ST_SNOOP;
            end else begin
              cur_src <= SRC_ARR;
              st_q    <= ST_RESP;
            end
          end else begin
            cur_way <= vic_way;
            if (v_q[cur_set][vic_way])
              st_q <= m_q[cur_set][vic_way] ? ST_EVSNP : ST_EVICT;
            else
              st_q <= ST_MEMRD;
          end
        end
        ST_SNOOP, ST_EVSNP: begin
          if (snp_rsp_valid) begin
            if (snp_rsp_dirty) begin
              dat_q[cur_set][cur_way] <= snp_rsp_data;
              d_q[cur_set][cur_way]   <= 1'b1;
            end
            m_q[cur_set][cur_way] <= 1'b0;
            if (st_q == ST_SNOOP) begin
              cur_src <= SRC_SNP;
              st_q    <= ST_RESP;
            end else begin
              st_q <= ST_EVICT;
            end
          end
        end
        ST_EVICT: begin
          v_q[cur_set][cur_way] <= 1'b0;
          st_q                  <= ST_MEMRD;
        end
        ST_MEMRD: begin
          if (mem_rsp_valid) begin
            v_q[cur_set][cur_way]    <= 1'b1;
            d_q[cur_set][cur_way]    <= 1'b0;
            m_q[cur_set][cur_way]    <= 1'b0;
            pres_q[cur_set][cur_way] <= '0;
            tag_q[cur_set][cur_way]  <= cur_tag;
            dat_q[cur_set][cur_way]  <= mem_rsp_data;
            cur_src                  <= SRC_MEM;
            st_q                     <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (cur_own) begin
            pres_q[cur_set][cur_way] <= core_bit;
            m_q[cur_set][cur_way]    <= 1'b1;
            own_q[cur_set][cur_way]  <= cur_core;
          end else begin
            pres_q[cur_set][cur_way] <= cw_pres | core_bit;
          end
          for (int w = 0; w < WAYS; w++)
            age_q[cur_set][w] <= ages_nxt[w*AGE_W +: AGE_W];
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Moore outputs
  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_core      = cur_core;
  assign rsp_src       = cur_src;
  assign rsp_data      = cw_data;
  assign mem_req_valid = (st_q == ST_MEMRD);
  assign mem_req_addr  = line_addr(cur_tag, cur_set);
  assign snp_valid     = (st_q == ST_SNOOP) || (st_q == ST_EVSNP);
  assign snp_core      = cw_owner;
  assign snp_addr      = line_addr(cw_tag, cur_set);
  assign wb_valid      = (st_q == ST_EVICT) && cw_dirty;
  assign wb_addr       = line_addr(cw_tag, cur_set);
  assign wb_data       = cw_data;

  always_comb begin
    binv_valid = 1'b0;
    binv_mask  = '0;
    binv_addr  = line_addr(cw_tag, cur_set);
    if (st_q == ST_EVICT) begin
      binv_valid = |cw_pres;
      binv_mask  = cw_pres;
    end else if (st_q == ST_RESP && cur_own) begin
      binv_valid = |others;
      binv_mask  = others;
    end
  end

endmodule

// File: rtl/llc_slice_checks.sv
module llc_slice_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [1:0] rsp_src,
  input logic       mem_req_valid,
  input logic       mem_rsp_valid,
  input logic       snp_valid,
  input logic       snp_rsp_valid,
  input logic       binv_valid,
  input logic       wb_valid,
  input logic       lookup_hit,
  input logic       lookup_mod_other
);
  // R2: a memory-sourced response follows a memory reply
  a_r2_mem_src_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src == 2'd0) |-> $past(mem_rsp_valid));

  // R4: a snoop-sourced response follows a snoop reply
  a_r4_snp_src_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src == 2'd2) |-> $past(snp_rsp_valid));

  // R3: an unmarked hit answers from the array in the next cycle
  a_r3_hit_from_array: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_hit && !lookup_mod_other) |=> (rsp_valid && rsp_src == 2'd1));

  // R8: a writeback always travels with a back-invalidate
  a_r8_wb_with_binv: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> binv_valid);

  // R1: response is a single-cycle pulse and activities never overlap
  a_r1_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r1_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rsp_valid, mem_req_valid, snp_valid}));
endmodule

bind llc_slice_resolver llc_slice_checks u_checks (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_ready        (req_ready),
  .rsp_valid        (rsp_valid),
  .rsp_src          (rsp_src),
  .mem_req_valid    (mem_req_valid),
  .mem_rsp_valid    (mem_rsp_valid),
  .snp_valid        (snp_valid),
  .snp_rsp_valid    (snp_rsp_valid),
  .binv_valid       (binv_valid),
  .wb_valid         (wb_valid),
  .lookup_hit       (lookup_hit),
  .lookup_mod_other (lookup_mod_other)
);

// File: tb/tb_llc_slice_resolver.sv
module tb_llc_slice_resolver;
  localparam int CORES = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0, req_ready, req_own = 1'b0;
  logic [1:0]        req_core = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid;
  logic [1:0]        rsp_core, rsp_src;
  logic [DATA_W-1:0] rsp_data;
  logic              mem_req_valid, mem_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic              snp_valid, snp_rsp_valid = 1'b0, snp_rsp_dirty = 1'b0;
  logic [1:0]        snp_core;
  logic [ADDR_W-1:0] snp_addr;
  logic [DATA_W-1:0] snp_rsp_data = '0;
  logic              binv_valid, wb_valid;
  logic [CORES-1:0]  binv_mask;
  logic [ADDR_W-1:0] binv_addr, wb_addr;
  logic [DATA_W-1:0] wb_data;

  llc_slice_resolver dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
    .req_addr(req_addr), .req_own(req_own),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_src(rsp_src), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .snp_valid(snp_valid), .snp_core(snp_core), .snp_addr(snp_addr),
    .snp_rsp_valid(snp_rsp_valid), .snp_rsp_dirty(snp_rsp_dirty), .snp_rsp_data(snp_rsp_data),
    .binv_valid(binv_valid), .binv_mask(binv_mask), .binv_addr(binv_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
    return ADDR_W'((tag << 8) | (set << 6) | off);
  endfunction

  function automatic logic [DATA_W-1:0] mem_pat(input logic [ADDR_W-1:0] a);
    return {16'hC0DE, a, a ^ 16'h5A5A, 16'h1234};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory and snoop responders: reply two cycles after a request appears
  int mem_wait = 0;
  int snp_wait = 0;
  logic              snp_dirty_cfg = 1'b0;
  logic [DATA_W-1:0] snp_data_cfg = '0;

  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && !mem_rsp_valid) begin
      if (mem_wait == 2) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_pat(mem_req_addr);
        mem_wait      <= 0;
      end else mem_wait <= mem_wait + 1;
    end
    snp_rsp_valid <= 1'b0;
    if (snp_valid && !snp_rsp_valid) begin
      if (snp_wait == 2) begin
        snp_rsp_valid <= 1'b1;
        snp_rsp_dirty <= snp_dirty_cfg;
        snp_rsp_data  <= snp_data_cfg;
        snp_wait      <= 0;
      end else snp_wait <= snp_wait + 1;
    end
  end

  // Observations of one transaction
  int                n_mem, n_snp, n_binv, n_wb;
  logic [ADDR_W-1:0] o_mem_addr, o_binv_addr, o_wb_addr;
  logic [1:0]        o_snp_core, o_src;
  logic [CORES-1:0]  o_binv_mask;
  logic [DATA_W-1:0] o_wb_data, o_data;
  logic              o_rsp;

  task automatic txn(input int core, input logic [ADDR_W-1:0] a, input logic own);
    n_mem = 0; n_snp = 0; n_binv = 0; n_wb = 0;
    o_binv_mask = '0; o_rsp = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'(core); req_addr = a; req_own = own;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mem_req_valid && !mem_rsp_valid) begin
        if (mem_wait == 0) n_mem++;
        o_mem_addr = mem_req_addr;
      end
      if (snp_valid && !snp_rsp_valid) begin
        if (snp_wait == 0) n_snp++;
        o_snp_core = snp_core;
      end
      if (binv_valid) begin
        n_binv++; o_binv_mask |= binv_mask; o_binv_addr = binv_addr;
      end
      if (wb_valid) begin
        n_wb++; o_wb_data = wb_data; o_wb_addr = wb_addr;
      end
      if (rsp_valid) begin
        o_rsp = 1'b1; o_src = rsp_src; o_data = rsp_data;
        check("R1 rsp_core", 64'(rsp_core), 64'(core));
        break;
      end
    end
    check("watchdog response seen", 64'(o_rsp), 64'd1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [ADDR_W-1:0] a_line;
  logic [DATA_W-1:0] d_val, e_val;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    check("R1 snp_valid", 64'(snp_valid), 64'd0);
    check("R1 binv_valid", 64'(binv_valid), 64'd0);
    check("R1 wb_valid", 64'(wb_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 64'(req_ready), 64'd1);

    // R2 miss from memory, unaligned request
    a_line = mk(16'h10, 0, 0);
    txn(0, mk(16'h10, 0, 6'h3F), 1'b0);
    check("R2 mem reads", n_mem, 1);
    check("R2 mem addr aligned", 64'(o_mem_addr), 64'(a_line));
    check("R2 src", 64'(o_src), 64'd0);
    check("R2 data", o_data, mem_pat(a_line));

    // R3 clean hit by another core
    txn(1, a_line, 1'b0);
    check("R3 src", 64'(o_src), 64'd1);
    check("R3 no mem", n_mem, 0);
    check("R3 no snoop", n_snp, 0);
    check("R3 data", o_data, mem_pat(a_line));

    // R6 ownership invalidates other sharers
    txn(2, a_line, 1'b1);
    check("R6 binv mask", 64'(o_binv_mask), 64'b0011);
    check("R6 binv addr", 64'(o_binv_addr), 64'(a_line));
    check("R6 src", 64'(o_src), 64'd1);

    // R4 snoop the single owner
    d_val = 64'hD1D1_2222_3333_4444;
    snp_dirty_cfg = 1'b1; snp_data_cfg = d_val;
    txn(0, a_line, 1'b0);
    check("R4 snoops", n_snp, 1);
    check("R4 snoop core", 64'(o_snp_core), 64'd2);
    check("R4 src", 64'(o_src), 64'd2);
    check("R4 data", o_data, d_val);
    check("R4 no mem", n_mem, 0);

    // R5 snooped data now in array, mark cleared
    txn(1, a_line, 1'b0);
    check("R5 src", 64'(o_src), 64'd1);
    check("R5 data", o_data, d_val);
    check("R5 no snoop", n_snp, 0);

    // R7 fill remaining 11 ways of set 0
    for (int k = 0; k < 11; k++) begin
      txn(0, mk(16'h20 + k, 0, 0), 1'b0);
      check("R7 fill src", 64'(o_src), 64'd0);
      check("R7 no binv", n_binv, 0);
      check("R7 no wb", n_wb, 0);
    end

    // R8 / R9 evict LRU line A (dirty, present in cores 0,1,2)
    txn(0, mk(16'h30, 0, 0), 1'b0);
    check("R8 binv mask", 64'(o_binv_mask), 64'b0111);
    check("R8 binv addr", 64'(o_binv_addr), 64'(a_line));
    check("R8 wb count", n_wb, 1);
    check("R8 wb data", o_wb_data, d_val);
    check("R8 wb addr", 64'(o_wb_addr), 64'(a_line));
    check("R9 fill src", 64'(o_src), 64'd0);

    // R9 touched line survives; next oldest clean line goes
    txn(0, mk(16'h20, 0, 0), 1'b0);
    check("R9 touch hit", 64'(o_src), 64'd1);
    txn(0, mk(16'h31, 0, 0), 1'b0);
    check("R9 victim addr", 64'(o_binv_addr), 64'(mk(16'h21, 0, 0)));
    check("R9 victim mask", 64'(o_binv_mask), 64'b0001);
    check("R8 clean no wb", n_wb, 0);

    // R6 ownership of 0x22 by core 3, then repeat without snoop
    txn(3, mk(16'h22, 0, 0), 1'b1);
    check("R6 own binv mask", 64'(o_binv_mask), 64'b0001);
    txn(3, mk(16'h22, 0, 0), 1'b1);
    check("R6 repeat no snoop", n_snp, 0);
    check("R6 repeat src", 64'(o_src), 64'd1);
    check("R6 repeat no binv", n_binv, 0);

    // Age every other line past 0x22
    for (int k = 3; k < 11; k++) begin
      txn(0, mk(16'h20 + k, 0, 0), 1'b0);
      check("R9 age hit", 64'(o_src), 64'd1);
    end
    txn(0, mk(16'h30, 0, 0), 1'b0);
    txn(0, mk(16'h20, 0, 0), 1'b0);
    txn(0, mk(16'h31, 0, 0), 1'b0);
    check("R9 age hit last", 64'(o_src), 64'd1);

    // R10 evict marked line: snoop owner first, write back snooped data
    e_val = 64'hE0E0_5555_6666_7777;
    snp_data_cfg = e_val;
    txn(0, mk(16'h32, 0, 0), 1'b0);
    check("R10 snoops", n_snp, 1);
    check("R10 snoop core", 64'(o_snp_core), 64'd3);
    check("R10 binv mask", 64'(o_binv_mask), 64'b1000);
    check("R10 binv addr", 64'(o_binv_addr), 64'(mk(16'h22, 0, 0)));
    check("R10 wb data", o_wb_data, e_val);
    check("R10 src", 64'(o_src), 64'd0);

    // R11 sweep sets 1..3, every core: miss then hit by neighbour
    for (int s = 1; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        txn(c, mk(16'h40 + c, s, 6'h15), 1'b0);
        check("R11 sweep miss src", 64'(o_src), 64'd0);
        check("R11 sweep mem addr", 64'(o_mem_addr), 64'(mk(16'h40 + c, s, 0)));
        check("R11 sweep data", o_data, mem_pat(mk(16'h40 + c, s, 0)));
        txn((c + 1) % 4, mk(16'h40 + c, s, 0), 1'b0);
        check("R11 sweep hit src", 64'(o_src), 64'd1);
        check("R11 sweep hit no mem", n_mem, 0);
      end
    end
    txn(2, mk(16'h40, 1, 0), 1'b0);
    check("R11 same tag other set kept", 64'(o_src), 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule